// File: doc/BRIEF.md
# Register Stack Frame Mapper

This block turns a 7-bit architectural general-register number into a physical register index. Numbers below 32 are fixed and come out unchanged. Numbers from 32 upward belong to the current procedure frame. They are placed in a circular pool of 96 physical registers, counted from a frame base pointer. A frame consists of a local region followed by an output region, and software chooses both sizes with an allocate operation.

A call hides the caller's local region. It moves the base forward past that region, so the caller's outputs become the callee's registers from 32 upward. A return takes the caller's base and sizes back from a small history stack.

The block keeps a count of how many pool registers hold live frame contents. When a frame grows past the pool, it asks an external memory engine to spill the oldest registers. When a return lands on a frame that was partly spilled, it asks for a fill. A request stays up until that engine acknowledges it, and the block refuses new frame operations while a request is up.

Top module: `rsm_mapper`

## Requirements
- R1: A register number below 32 maps to the same physical index and is never flagged illegal.
- R2: A number v of 32 or more, with v-32 inside the frame, maps to 32 + ((base + v - 32) mod 96).
- R3: A number v of 32 or more, with v-32 not smaller than the frame size (local + output), raises regIllegal and drives pReg to 0.
- R4: Allocate (opKind 2'b11) replaces the local and output sizes and leaves the base unchanged. If local + output exceeds 96, the operation is ignored.
- R5: Call (opKind 2'b01) advances the base by the caller's local size mod 96. The callee's local size becomes 0 and its output size equals the caller's output size, so the caller's outputs appear from 32 upward.
- R6: Return (opKind 2'b10) restores the base, local size and output size saved by the matching call.
- R7: When live registers exceed 96, spillReq rises with xferCount equal to the excess. It stays up until memAck, after which the live count is 96.
- R8: When a return leaves fewer live registers than the restored frame size, fillReq rises with xferCount equal to the shortfall. It stays up until memAck.
- R9: Frame operations are ignored while busy (a spill or fill is pending). A call is ignored when the history stack is full, and a return is ignored when it is empty.
- R10: After reset the frame is empty (size 0, base 0, no history), so every number of 32 or more is illegal and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| vReg | input | 7 | Architectural register number to translate |
| pReg | output | 7 | Physical register index |
| regIllegal | output | 1 | vReg lies beyond the current frame |
| opValid | input | 1 | Frame operation strobe |
| opKind | input | 2 | 01 call, 10 return, 11 allocate, 00 none |
| opLocal | input | 7 | New local size for allocate |
| opOut | input | 7 | New output size for allocate |
| busy | output | 1 | A spill or fill is pending; operations are refused |
| spillReq | output | 1 | Spill the oldest live registers to memory |
| fillReq | output | 1 | Reload spilled registers of the restored frame |
| xferCount | output | 7 | Number of registers to spill or fill |
| memAck | input | 1 | Memory engine finished the pending transfer |

## Verification
The checker assumes that memAck arrives only while a spill or fill request is up. That is why it can require a request to hold on every cycle without an acknowledge. It also assumes vReg is a 7-bit number, so every value is either fixed or stacked. The stimulus raises memAck only during request cycles. It issues a call during a spill on purpose, to show the call is refused, and it never acknowledges while idle.

// File: rtl/rsm_pkg.sv
package rsm_pkg;
  localparam int POOL_SIZE  = 96;
  localparam int NUM_STATIC = 32;
  localparam int VREG_W     = 7;
  localparam int HIST_DEPTH = 8;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_CALL  = 2'b01,
    OP_RET   = 2'b10,
    OP_ALLOC = 2'b11
  } op_e;

  typedef struct packed {
    logic doCall;
    logic doRet;
    logic doAlloc;
    logic spillDone;
    logic fillDone;
  } strobe_t;
endpackage

// File: rtl/rsm_datapath.sv
module rsm_datapath
  import rsm_pkg::*;
#(
  parameter int POOL  = POOL_SIZE,
  parameter int NSTAT = NUM_STATIC,
  parameter int VW    = VREG_W,
  parameter int DEPTH = HIST_DEPTH
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  input  logic [VW-1:0] newLoc,
  input  logic [VW-1:0] newOut,
  input  logic [VW-1:0] vReg,
  output logic [VW-1:0] pReg,
  output logic          regIllegal,
  output logic          overCommit,
  output logic          underFill,
  output logic [VW-1:0] xferCount,
  output logic          histFull,
  output logic          histEmpty
);
  localparam int CW   = $clog2(2 * POOL + 1);
  localparam int HW   = $clog2(DEPTH + 1);
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [VW-1:0] base, curLoc, curOut;
  logic [CW-1:0] dirty;
  logic [HW-1:0] histCnt;
  logic [VW-1:0] histBase [DEPTH];
  logic [VW-1:0] histLoc  [DEPTH];
  logic [VW-1:0] histOut  [DEPTH];

  logic [CW-1:0] sof, offW, sumW, callSum, allocSof;
  logic [PTRW-1:0] wrIdx, topIdx;
  logic isStacked;

  assign sof      = CW'(curLoc) + CW'(curOut);
  assign allocSof = CW'(newLoc) + CW'(newOut);
  assign wrIdx    = PTRW'(histCnt);
  assign topIdx   = PTRW'(histCnt - HW'(1));

  // translation: offset into frame, then modular add onto the base
  assign isStacked = vReg >= VW'(NSTAT);
  assign offW      = CW'(vReg) - CW'(NSTAT);

  always_comb begin
    sumW = CW'(base) + offW;
    if (sumW >= CW'(POOL)) sumW = sumW - CW'(POOL);
  end

  always_comb begin
    callSum = CW'(base) + CW'(curLoc);
    if (callSum >= CW'(POOL)) callSum = callSum - CW'(POOL);
  end

  assign regIllegal = isStacked && (offW >= sof);
  assign pReg = !isStacked ? vReg : (regIllegal ? '0 : VW'(sumW + CW'(NSTAT)));

  assign overCommit = dirty > CW'(POOL);
  assign underFill  = dirty < sof;
  assign histFull   = histCnt == HW'(DEPTH);
  assign histEmpty  = histCnt == '0;

  always_comb begin
    if (overCommit)     xferCount = VW'(dirty - CW'(POOL));
    else if (underFill) xferCount = VW'(sof - dirty);
    else                xferCount = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      base    <= '0;
      curLoc  <= '0;
      curOut  <= '0;
      dirty   <= '0;
      histCnt <= '0;
    end else if (stb.doAlloc) begin
      curLoc <= newLoc;
      curOut <= newOut;
      dirty  <= dirty - sof + allocSof;
    end else if (stb.doCall) begin
      base    <= VW'(callSum);
      curLoc  <= '0;
      histCnt <= histCnt + HW'(1);
    end else if (stb.doRet) begin
      base    <= histBase[topIdx];
      curLoc  <= histLoc[topIdx];
      curOut  <= histOut[topIdx];
      histCnt <= histCnt - HW'(1);
      dirty   <= dirty - sof + CW'(histOut[topIdx]);
    end else if (stb.spillDone) begin
      dirty <= CW'(POOL);
    end else if (stb.fillDone) begin
      dirty <= sof;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.doCall) begin
      histBase[wrIdx] <= base;
      histLoc[wrIdx]  <= curLoc;
      histOut[wrIdx]  <= curOut;
    end
  end
endmodule

// File: rtl/rsm_control.sv
module rsm_control
  import rsm_pkg::*;
#(
  parameter int POOL = POOL_SIZE,
  parameter int VW   = VREG_W
) (
  input  logic          opValid,
  input  logic [1:0]    opKind,
  input  logic [VW-1:0] opLocal,
  input  logic [VW-1:0] opOut,
  input  logic          memAck,
  input  logic          overCommit,
  input  logic          underFill,
  input  logic          histFull,
  input  logic          histEmpty,
  output strobe_t       stb,
  output logic          busy
);
  localparam int SW = VW + 1;

  logic accept, allocOk;

  assign busy    = overCommit | underFill;
  assign accept  = opValid && !busy;
  assign allocOk = (SW'(opLocal) + SW'(opOut)) <= SW'(POOL);

  always_comb begin
    stb           = '0;
    stb.doCall    = accept && (opKind == OP_CALL) && !histFull;
    stb.doRet     = accept && (opKind == OP_RET) && !histEmpty;
    stb.doAlloc   = accept && (opKind == OP_ALLOC) && allocOk;
    stb.spillDone = memAck && overCommit;
    stb.fillDone  = memAck && underFill;
  end
endmodule

// File: rtl/rsm_mapper.sv
module rsm_mapper
  import rsm_pkg::*;
#(
  parameter int POOL_SIZE_P  = POOL_SIZE,
  parameter int NUM_STATIC_P = NUM_STATIC,
  parameter int VREG_W_P     = VREG_W,
  parameter int HIST_DEPTH_P = HIST_DEPTH
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [VREG_W_P-1:0] vReg,
  output logic [VREG_W_P-1:0] pReg,
  output logic                regIllegal,
  input  logic                opValid,
  input  logic [1:0]          opKind,
  input  logic [VREG_W_P-1:0] opLocal,
  input  logic [VREG_W_P-1:0] opOut,
  output logic                busy,
  output logic                spillReq,
  output logic                fillReq,
  output logic [VREG_W_P-1:0] xferCount,
  input  logic                memAck
);
  strobe_t stb;
  logic overCommit, underFill, histFull, histEmpty;

  rsm_control #(.POOL(POOL_SIZE_P), .VW(VREG_W_P)) u_ctrl (
    .opValid(opValid), .opKind(opKind), .opLocal(opLocal), .opOut(opOut),
    .memAck(memAck), .overCommit(overCommit), .underFill(underFill),
    .histFull(histFull), .histEmpty(histEmpty), .stb(stb), .busy(busy)
  );

  rsm_datapath #(
    .POOL(POOL_SIZE_P), .NSTAT(NUM_STATIC_P), .VW(VREG_W_P), .DEPTH(HIST_DEPTH_P)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .newLoc(opLocal), .newOut(opOut),
    .vReg(vReg), .pReg(pReg), .regIllegal(regIllegal),
    .overCommit(overCommit), .underFill(underFill), .xferCount(xferCount),
    .histFull(histFull), .histEmpty(histEmpty)
  );

  assign spillReq = overCommit;
  assign fillReq  = underFill;
endmodule

// File: rtl/rsm_checker.sv
module rsm_checker #(
  parameter int POOL  = 96,
  parameter int NSTAT = 32,
  parameter int VW    = 7
) (
  input logic          clk,
  input logic          rstN,
  input logic [VW-1:0] vReg,
  input logic [VW-1:0] pReg,
  input logic          regIllegal,
  input logic          spillReq,
  input logic          fillReq,
  input logic [VW-1:0] xferCount,
  input logic          memAck
);
  assert_static_identity_R1: assert property (@(posedge clk) disable iff (!rstN)
    (vReg < VW'(NSTAT)) |-> (pReg == vReg && !regIllegal));

  assert_stacked_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    (vReg >= VW'(NSTAT) && !regIllegal) |-> (pReg >= VW'(NSTAT)));

  assert_illegal_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    regIllegal |-> (pReg == '0));

  assert_spill_count_R7: assert property (@(posedge clk) disable iff (!rstN)
    spillReq |-> (xferCount != '0 && xferCount <= VW'(POOL)));

  assert_spill_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (spillReq && !memAck) |=> spillReq);

  assert_fill_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (fillReq && !memAck) |=> fillReq);

  assert_req_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(spillReq && fillReq));
endmodule

bind rsm_mapper rsm_checker #(.POOL(POOL_SIZE_P), .NSTAT(NUM_STATIC_P), .VW(VREG_W_P)) u_chk (
  .clk(clk), .rstN(rstN), .vReg(vReg), .pReg(pReg), .regIllegal(regIllegal),
  .spillReq(spillReq), .fillReq(fillReq), .xferCount(xferCount), .memAck(memAck)
);

// File: tb/test_rsm_mapper.sv
module test_rsm_mapper;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [6:0] vReg = '0, opLocal = '0, opOut = '0;
  logic [1:0] opKind = '0;
  logic opValid = 1'b0, memAck = 1'b0;
  logic [6:0] pReg, xferCount;
  logic regIllegal, busy, spillReq, fillReq;
  int testCnt = 0, failCnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rsm_mapper i_rsm_mapper (
    .clk(clk), .rstN(rstN), .vReg(vReg), .pReg(pReg), .regIllegal(regIllegal),
    .opValid(opValid), .opKind(opKind), .opLocal(opLocal), .opOut(opOut),
    .busy(busy), .spillReq(spillReq), .fillReq(fillReq),
    .xferCount(xferCount), .memAck(memAck)
  );

  typedef struct packed {
    logic [1:0] kind;
    logic [6:0] loc;
    logic [6:0] out;
    logic       ack;
    logic [6:0] v;
    logic [6:0] expP;
    logic       expIll;
    logic       expSpill;
    logic       expFill;
    logic [6:0] expCnt;
    logic [3:0] req;
  } vec_t;

  // kind: 0 none, 1 call, 2 return, 3 allocate
  localparam vec_t VECS [16] = '{
    '{2'd0, 7'd0,  7'd0,  1'b0, 7'd5,   7'd5,   1'b0, 1'b0, 1'b0, 7'd0,  4'd1},  // R1
    '{2'd0, 7'd0,  7'd0,  1'b0, 7'd32,  7'd0,   1'b1, 1'b0, 1'b0, 7'd0,  4'd10}, // R10
    '{2'd3, 7'd40, 7'd40, 1'b0, 7'd32,  7'd32,  1'b0, 1'b0, 1'b0, 7'd0,  4'd4},  // R4
    '{2'd0, 7'd0,  7'd0,  1'b0, 7'd111, 7'd111, 1'b0, 1'b0, 1'b0, 7'd0,  4'd2},  // R2
    '{2'd0, 7'd0,  7'd0,  1'b0, 7'd112, 7'd0,   1'b1, 1'b0, 1'b0, 7'd0,  4'd3},  // R3
    '{2'd1, 7'd0,  7'd0,  1'b0, 7'd32,  7'd72,  1'b0, 1'b0, 1'b0, 7'd0,  4'd5},  // R5
    '{2'd0, 7'd0,  7'd0,  1'b0, 7'd71,  7'd111, 1'b0, 1'b0, 1'b0, 7'd0,  4'd5},  // R5
    '{2'd0, 7'd0,  7'd0,  1'b0, 7'd72,  7'd0,   1'b1, 1'b0, 1'b0, 7'd0,  4'd5},  // R5
    '{2'd3, 7'd30, 7'd40, 1'b0, 7'd101, 7'd45,  1'b0, 1'b1, 1'b0, 7'd14, 4'd7},  // R7, R2 wrap
    '{2'd1, 7'd0,  7'd0,  1'b0, 7'd101, 7'd45,  1'b0, 1'b1, 1'b0, 7'd14, 4'd9},  // R9 busy
    '{2'd0, 7'd0,  7'd0,  1'b1, 7'd101, 7'd45,  1'b0, 1'b0, 1'b0, 7'd0,  4'd7},  // R7 ack
    '{2'd2, 7'd0,  7'd0,  1'b0, 7'd32,  7'd32,  1'b0, 1'b0, 1'b1, 7'd14, 4'd8},  // R8, R6
    '{2'd0, 7'd0,  7'd0,  1'b1, 7'd111, 7'd111, 1'b0, 1'b0, 1'b0, 7'd0,  4'd6},  // R6
    '{2'd3, 7'd60, 7'd50, 1'b0, 7'd111, 7'd111, 1'b0, 1'b0, 1'b0, 7'd0,  4'd4},  // R4 oversize
    '{2'd0, 7'd0,  7'd0,  1'b0, 7'd112, 7'd0,   1'b1, 1'b0, 1'b0, 7'd0,  4'd4},  // R4
    '{2'd2, 7'd0,  7'd0,  1'b0, 7'd111, 7'd111, 1'b0, 1'b0, 1'b0, 7'd0,  4'd9}   // R9 empty
  };

  task automatic check(input string tag, input logic [6:0] expP, input logic expIll,
                       input logic expSpill, input logic expFill, input logic [6:0] expCnt);
    testCnt++;
    if (pReg !== expP || regIllegal !== expIll || spillReq !== expSpill ||
        fillReq !== expFill || xferCount !== expCnt || busy !== (expSpill | expFill)) begin
      failCnt++;
      $display("FAIL %s: got p=%0d ill=%0b sp=%0b fi=%0b cnt=%0d busy=%0b, exp p=%0d ill=%0b sp=%0b fi=%0b cnt=%0d",
               tag, pReg, regIllegal, spillReq, fillReq, xferCount, busy,
               expP, expIll, expSpill, expFill, expCnt);
    end
  endtask

  task automatic step(input logic [1:0] kind, input logic [6:0] loc, input logic [6:0] out,
                      input logic ack, input logic [6:0] v);
    @(negedge clk);
    opValid = (kind != 2'd0);
    opKind  = kind;
    opLocal = loc;
    opOut   = out;
    memAck  = ack;
    vReg    = v;
    @(posedge clk);
    #1;
    opValid = 1'b0;
    memAck  = 1'b0;
    #4;
  endtask

  task automatic look(input logic [6:0] v);
    vReg = v;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 16; i++) begin
      step(VECS[i].kind, VECS[i].loc, VECS[i].out, VECS[i].ack, VECS[i].v);
      check($sformatf("vec %0d R%0d", i, VECS[i].req), VECS[i].expP, VECS[i].expIll,
            VECS[i].expSpill, VECS[i].expFill, VECS[i].expCnt);
    end
    // R9: fill the history stack, then one extra call must be refused
    for (int k = 0; k < 8; k++) step(2'd1, 7'd0, 7'd0, 1'b0, 7'd32);
    step(2'd3, 7'd10, 7'd10, 1'b0, 7'd32);
    step(2'd1, 7'd0, 7'd0, 1'b0, 7'd32);
    check("R9 full history", 7'd72, 1'b0, 1'b0, 1'b0, 7'd0);
    look(7'd51);
    check("R9 frame kept", 7'd91, 1'b0, 1'b0, 1'b0, 7'd0);
    look(7'd52);
    check("R3 edge", 7'd0, 1'b1, 1'b0, 1'b0, 7'd0);
    // R6: return to the frame saved by the last accepted call
    step(2'd2, 7'd0, 7'd0, 1'b0, 7'd71);
    check("R6 restore", 7'd111, 1'b0, 1'b0, 1'b0, 7'd0);
    // R10: reset empties the frame
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    look(7'd40);
    check("R10 after reset", 7'd0, 1'b1, 1'b0, 1'b0, 7'd0);
    look(7'd31);
    check("R1 after reset", 7'd31, 1'b0, 1'b0, 1'b0, 7'd0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      testCnt++;
      failCnt++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end
endmodule